// File: doc/BRIEF.md
# Precomputed Magnitude Comparator

This block compares two unsigned operands and reports whether the first is strictly greater than the second. It is built for low switching activity. Each operand is split into its top bit and its lower bits. The pair of top bits goes into a two-bit register that captures every valid operand pair. The lower bits of both operands go into a wider register, and that register only captures when the two top bits are equal. If the top bits differ, they already decide the answer, so the wide register keeps its old contents and its comparator logic does not toggle.

The result flag comes out of the registered stage. It is valid one clock after the valid strobe, and it stays put until the next strobe. A saturating counter records how many strobes skipped the low-order load. This lets an integrator confirm how much datapath activity was avoided on a real workload.

Top module: `prec_cmp`

## Requirements
- R1: While rst_ni is low, and right after it is released, gt_o is 0 and skip_cnt_o is 0. Reset is asynchronous and clears both at any time.
- R2: If valid_i is high with a_i[DATA_W-1]=1 and b_i[DATA_W-1]=0, gt_o is 1 one cycle later, whatever the lower bits are.
- R3: If valid_i is high with a_i[DATA_W-1]=0 and b_i[DATA_W-1]=1, gt_o is 0 one cycle later, whatever the lower bits are.
- R4: If valid_i is high and the top bits of a_i and b_i are equal, gt_o one cycle later is 1 exactly when a_i[DATA_W-2:0] > b_i[DATA_W-2:0], compared as unsigned numbers.
- R5: If valid_i is high with a_i equal to b_i, gt_o is 0 one cycle later.
- R6: When a valid pair has differing top bits, the low-order register does not load. skip_cnt_o then rises by exactly 1 on the next cycle. A valid pair with equal top bits, or a cycle with valid_i low, leaves skip_cnt_o unchanged.
- R7: skip_cnt_o saturates at 2^CNT_W-1. Once there, further suppressed loads leave it at that value.
- R8: With valid_i low, gt_o holds its last value, even if a_i and b_i change.
- R9: The latency is one cycle whether or not the low-order register loaded. In a back-to-back stream, gt_o in each cycle reflects the pair strobed in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair strobe |
| a_i | input | DATA_W | Operand A, unsigned |
| b_i | input | DATA_W | Operand B, unsigned |
| gt_o | output | 1 | A > B for the last strobed pair |
| skip_cnt_o | output | CNT_W | Saturating count of suppressed low-order loads |

## Verification
Every result here, the flag and the counter alike, changes on the first rising edge after the strobe. The bench drives inputs on the falling edge and drops valid_i on the next falling edge. It samples at that same falling edge, which lands exactly one register stage after the strobe. Streamed tests keep valid_i high for consecutive cycles and compare each falling-edge sample against the pair strobed one edge earlier. This pins down the equal latency of the loaded and the suppressed paths. The hold and counter checks sample again after idle cycles, to confirm nothing moved.

// File: rtl/prec_cmp_pkg.sv
package prec_cmp_pkg;
  typedef struct packed {
    logic a_top;
    logic b_top;
  } top_pair_t;

  function automatic logic tops_decide(top_pair_t p);
    return p.a_top ^ p.b_top;
  endfunction
endpackage

// File: rtl/prec_top_stage.sv
module prec_top_stage
  import prec_cmp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  logic      a_top_i,
  input  logic      b_top_i,
  output top_pair_t pair_o,
  output logic      lo_load_o,
  output logic      skip_o
);
  top_pair_t pair_d, pair_q;

  assign pair_d = '{a_top: a_top_i, b_top: b_top_i};
  // precompute: top bits alone settle the answer
  assign skip_o    = valid_i & tops_decide(pair_d);
  assign lo_load_o = valid_i & ~tops_decide(pair_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pair_q <= '0;
    else if (valid_i) pair_q <= pair_d;
  end

  assign pair_o = pair_q;
endmodule

// File: rtl/prec_lo_reg.sv
module prec_lo_reg #(
  parameter int unsigned W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  logic [W-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  assign a_o = a_q;
  assign b_o = b_q;
endmodule

// File: rtl/prec_gt_chain.sv
module prec_gt_chain #(
  parameter int unsigned W = 15
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o
);
  logic [W:0] gt_c;

  assign gt_c[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    // a higher bit decides; when it ties, pass up the lower result
    assign gt_c[i+1] = (a_i[i] & ~b_i[i]) | (~(a_i[i] ^ b_i[i]) & gt_c[i]);
  end
  assign gt_o = gt_c[W];
endmodule

// File: rtl/prec_sat_cnt.sv
module prec_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MaxVal = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (inc_i && cnt_q != MaxVal) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/prec_cmp.sv
module prec_cmp
  import prec_cmp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              gt_o,
  output logic [CNT_W-1:0]  skip_cnt_o
);
  localparam int unsigned LoW = DATA_W - 1;

  top_pair_t      pair_q;
  logic           lo_load, skip;
  logic [LoW-1:0] lo_a_q, lo_b_q;
  logic           lo_gt;

  prec_top_stage u_top (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .a_top_i   (a_i[DATA_W-1]),
    .b_top_i   (b_i[DATA_W-1]),
    .pair_o    (pair_q),
    .lo_load_o (lo_load),
    .skip_o    (skip)
  );

  prec_lo_reg #(.W(LoW)) u_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (lo_load),
    .a_i    (a_i[LoW-1:0]),
    .b_i    (b_i[LoW-1:0]),
    .a_o    (lo_a_q),
    .b_o    (lo_b_q)
  );

  prec_gt_chain #(.W(LoW)) u_cmp (
    .a_i  (lo_a_q),
    .b_i  (lo_b_q),
    .gt_o (lo_gt)
  );

  prec_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (skip),
    .cnt_o  (skip_cnt_o)
  );

  // g(X) reads only the registered top pair
  assign gt_o = tops_decide(pair_q) ? pair_q.a_top : lo_gt;
endmodule

// File: rtl/prec_cmp_chk.sv
module prec_cmp_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              gt_o,
  input logic [CNT_W-1:0]  skip_cnt_o,
  input logic [DATA_W-2:0] lo_a_q,
  input logic [DATA_W-2:0] lo_b_q
);
  localparam logic [CNT_W-1:0] CntMax = '1;
  logic tops_differ;
  assign tops_differ = a_i[DATA_W-1] ^ b_i[DATA_W-1];

  // R2
  a_top_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && a_i[DATA_W-1] && !b_i[DATA_W-1] |=> gt_o);

  // R3
  b_top_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !a_i[DATA_W-1] && b_i[DATA_W-1] |=> !gt_o);

  // R5
  equal_not_gt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (a_i == b_i) |=> !gt_o);

  // R6
  lo_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && tops_differ |=> $stable(lo_a_q) && $stable(lo_b_q));

  // R6
  skip_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && tops_differ && skip_cnt_o != CntMax |=> skip_cnt_o == $past(skip_cnt_o) + 1'b1);

  // R6
  no_skip_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && tops_differ) |=> $stable(skip_cnt_o));

  // R7
  cnt_saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_cnt_o == CntMax |=> skip_cnt_o == CntMax);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(gt_o));
endmodule

bind prec_cmp prec_cmp_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .gt_o       (gt_o),
  .skip_cnt_o (skip_cnt_o),
  .lo_a_q     (lo_a_q),
  .lo_b_q     (lo_b_q)
);

// File: tb/sim_prec_cmp.sv
module sim_prec_cmp;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [DATA_W-1:0] a_i = '0, b_i = '0;
  logic              gt_o;
  logic [CNT_W-1:0]  skip_cnt_o;

  int n_chk = 0, n_fail = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prec_cmp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i), .gt_o(gt_o), .skip_cnt_o(skip_cnt_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_gt(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    return a > b;
  endfunction

  function automatic bit tops_diff(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    return a[DATA_W-1] != b[DATA_W-1];
  endfunction

  // one strobe, result sampled one edge later
  task automatic strobe(string req, logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    @(negedge clk);
    a_i = a; b_i = b; valid_i = 1'b1;
    if (tops_diff(a, b) && exp_cnt < CMAX) exp_cnt++;
    @(negedge clk);
    valid_i = 1'b0;
    check(req, gt_o, model_gt(a, b));
    check({req, " cnt"}, skip_cnt_o, exp_cnt);
  endtask

  task automatic t_reset();
    check("R1 gt", gt_o, 0);
    check("R1 cnt", skip_cnt_o, 0);
  endtask

  task automatic t_a_top();
    strobe("R2", 16'h8000, 16'h7fff);
    strobe("R2", 16'h8001, 16'h0000);
    strobe("R2", 16'hffff, 16'h7fff);
  endtask

  task automatic t_b_top();
    strobe("R3", 16'h7fff, 16'h8000);
    strobe("R3", 16'h0000, 16'hffff);
  endtask

  task automatic t_low();
    strobe("R4", 16'h0001, 16'h0000);
    strobe("R4", 16'h0000, 16'h0001);
    strobe("R4", 16'h8123, 16'h8122);
    strobe("R4", 16'hfffe, 16'hffff);
    strobe("R4", 16'h4000, 16'h3fff);
    strobe("R4", 16'h7fff, 16'h0000);
  endtask

  task automatic t_equal();
    strobe("R5", 16'h0000, 16'h0000);
    strobe("R5", 16'hffff, 16'hffff);
    strobe("R5", 16'h8a5a, 16'h8a5a);
  endtask

  task automatic t_hold();
    strobe("R8", 16'h9000, 16'h1000);
    @(negedge clk);
    a_i = 16'h0000; b_i = 16'hffff;
    repeat (3) @(negedge clk);
    check("R8 gt hold", gt_o, 1);
    check("R6 cnt idle", skip_cnt_o, exp_cnt);
  endtask

  // R9: back-to-back stream, mixed paths
  task automatic t_stream();
    logic [DATA_W-1:0] sa [8] = '{16'h8000,16'h0005,16'h0003,16'h7000,16'hc000,16'h8fff,16'h0000,16'h1234};
    logic [DATA_W-1:0] sb [8] = '{16'h0001,16'h0004,16'h0003,16'h9000,16'h4000,16'h8ffe,16'h8000,16'h1233};
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      a_i = sa[i]; b_i = sb[i]; valid_i = 1'b1;
      if (tops_diff(sa[i], sb[i]) && exp_cnt < CMAX) exp_cnt++;
      @(negedge clk);
      check("R9 stream gt", gt_o, model_gt(sa[i], sb[i]));
      check("R9 stream cnt", skip_cnt_o, exp_cnt);
    end
    valid_i = 1'b0;
  endtask

  task automatic t_saturate();
    @(negedge clk);
    a_i = 16'h8000; b_i = 16'h0000; valid_i = 1'b1;
    while (exp_cnt < CMAX + 4) begin
      @(negedge clk);
      exp_cnt++;
    end
    valid_i = 1'b0;
    exp_cnt = CMAX;
    check("R7 saturate", skip_cnt_o, CMAX);
    strobe("R7 after sat", 16'h0000, 16'h8000);
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    #1 rst_ni = 1'b0;
    #0.5;
    check("R1 async gt", gt_o, 0);
    check("R1 async cnt", skip_cnt_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    exp_cnt = 0;
    strobe("R6 after reset", 16'h8000, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_a_top();
    t_b_top();
    t_low();
    t_equal();
    t_hold();
    t_stream();
    t_saturate();
    t_async_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule